// File: doc/BRIEF.md
# Iterative DES Block Cipher Core

This core encrypts or decrypts a single 64-bit block under a 64-bit key with the sixteen-round Feistel cipher of the Data Encryption Standard. A single round datapath is reused on every clock, so an operation takes sixteen round cycles. The subkeys come from an on-the-fly schedule that rotates two 28-bit key halves once per round. Decryption runs on the same hardware; the only difference is that the schedule walks the subkeys from the sixteenth back to the first.

A caller presents the key, the data block and the direction, then pulses `start` for one cycle while the core is idle. The core captures all three on that edge. The inputs may change freely afterwards. When the last round has been computed, `done` rises and the result appears on `block_out`. Both stay as they are until the next accepted start. Chaining modes and padding are left to the surrounding logic.

Top module: `des_iter_core`

## Requirements
- R1: While `rst_n` is low and after its release with no start, `done` is 0 and `block_out` is all zeros.
- R2: With `encrypt`=1, key 133457799BBCDFF1 and block 0123456789ABCDEF give 85E813540F0AB405. Key 0E329232EA6D0D73 and block 8787878787878787 give 0000000000000000.
- R3: With `encrypt`=0 the core inverts R2. Ciphertext 85E813540F0AB405 under key 133457799BBCDFF1 returns 0123456789ABCDEF. Zero under key 0E329232EA6D0D73 returns 8787878787878787.
- R4: `done` is low for the 15 cycles after the edge that accepts `start` and is high after the 16th edge that follows it. Inputs that change after the accepting edge do not alter the result.
- R5: Once high, `done` and `block_out` hold their values, whatever the data, key and direction inputs do, until the next accepted start. `done` falls on the edge that accepts a new start.
- R6: A `start` pulse that arrives while an operation is in progress is ignored. The running operation finishes on its original cycle with its original result.
- R7: The least significant bit of each key byte (parity bits, mask 0101010101010101) has no effect on the result.
- R8: Encrypting the bitwise complement of the block under the bitwise complement of the key gives the bitwise complement of the ciphertext.
- R9: Under key 0101010101010101, whose subkeys are all zero, encrypting a block twice returns the original block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation; ignored while busy |
| encrypt | input | 1 | 1 selects encryption, 0 selects decryption; captured with start |
| key_in | input | 64 | Cipher key, parity bits unused |
| block_in | input | 64 | Data block to transform |
| block_out | output | 64 | Result block, valid while done is high |
| done | output | 1 | High from completion until the next accepted start |

## Verification
The known-answer vectors in both directions catch a wrong table entry, a swapped half after the last round, and a subkey sequence that runs in the wrong order. The bench scrambles the inputs right after every start and injects a stray start mid-operation. A core that fails to latch its operands would then return garbage, and one that honours the stray start would finish late or with the wrong block. Flipping the parity bits catches a key-selection permutation that reads a discarded bit. The complementation and weak-key cases test the schedule and round in ways that no single vector covers. The per-cycle `done` comparison catches an off-by-one in the round counter, where the flag would rise one cycle early or late.

// File: rtl/dcore_pkg.sv
package dcore_pkg;

  localparam int BLK_W  = 64;
  localparam int HALF_W = BLK_W / 2;
  localparam int SUB_W  = 48;
  localparam int CD_W   = 56;
  localparam int HCD_W  = CD_W / 2;
  localparam int ROUNDS = 16;
  localparam int CNT_W  = $clog2(ROUNDS);
  localparam int NSBOX  = 8;

  localparam int P_TAB [32] = '{
    16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
    2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};

  localparam int KSEL_TAB [56] = '{
    57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
    10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
    14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};

  localparam int KCMP_TAB [48] = '{
    14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
    23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // Four rows per substitution box; column 0 sits in the top nibble.
  localparam logic [63:0] SBOX_ROWS [32] = '{
    64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D,
    64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9,
    64'hA09E63F51DC7B428, 64'hD709346A285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C,
    64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E,
    64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453,
    64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D,
    64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C,
    64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B};

  // Source position (1 = MSB) feeding output position i+1 of the initial permutation.
  function automatic int ip_src(input int i);
    int r;
    int c;
    r = i / 8;
    c = i % 8;
    if (r < 4) return 58 - 8 * c + 2 * r;
    else       return 57 - 8 * c + 2 * (r - 4);
  endfunction

  function automatic logic [BLK_W-1:0] perm_in(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W - ip_src(i)];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] perm_out(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W - ip_src(i)] = x[BLK_W-1-i];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] expand(input logic [HALF_W-1:0] r);
    logic [SUB_W-1:0] y;
    int src;
    for (int i = 0; i < SUB_W; i++) begin
      src = ((4 * (i / 6) + (i % 6) + 31) % 32) + 1;
      y[SUB_W-1-i] = r[HALF_W - src];
    end
    return y;
  endfunction

  function automatic logic [HALF_W-1:0] pbox(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W - P_TAB[i]];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] key_select(input logic [BLK_W-1:0] k);
    logic [CD_W-1:0] y;
    for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = k[BLK_W - KSEL_TAB[i]];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] key_compress(input logic [CD_W-1:0] cd);
    logic [SUB_W-1:0] y;
    for (int i = 0; i < SUB_W; i++) y[SUB_W-1-i] = cd[CD_W - KCMP_TAB[i]];
    return y;
  endfunction

  function automatic logic [3:0] sbox_lookup(input int box, input logic [5:0] six);
    logic [63:0] row_word;
    int row;
    int col;
    row = int'({six[5], six[0]});
    col = int'(six[4:1]);
    row_word = SBOX_ROWS[box * 4 + row];
    return row_word[(15 - col) * 4 +: 4];
  endfunction

  // Rotation amount used to reach subkey n (1..16) from subkey n-1.
  function automatic int shift_of(input int n);
    if (n == 1 || n == 2 || n == 9 || n == 16) return 1;
    else return 2;
  endfunction

  function automatic logic [HCD_W-1:0] rotl_half(input logic [HCD_W-1:0] h, input int n);
    if (n == 1) return {h[HCD_W-2:0], h[HCD_W-1]};
    else        return {h[HCD_W-3:0], h[HCD_W-1:HCD_W-2]};
  endfunction

  function automatic logic [HCD_W-1:0] rotr_half(input logic [HCD_W-1:0] h, input int n);
    if (n == 1) return {h[0], h[HCD_W-1:1]};
    else        return {h[1:0], h[HCD_W-1:2]};
  endfunction

  function automatic logic [CD_W-1:0] rot_cd(input logic [CD_W-1:0] cd, input int n,
                                             input logic left);
    if (left) return {rotl_half(cd[CD_W-1:HCD_W], n), rotl_half(cd[HCD_W-1:0], n)};
    else      return {rotr_half(cd[CD_W-1:HCD_W], n), rotr_half(cd[HCD_W-1:0], n)};
  endfunction

endpackage

// File: rtl/dcore_seq.sv
module dcore_seq
  import dcore_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             busy,
  output logic             last,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ROUNDS - 1);

  assign accept = start && !busy;
  assign last   = busy && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  a_r6_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && cnt == $past(cnt) + 1'b1));

  a_r4_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last));

  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

// File: rtl/dcore_keysched.sv
module dcore_keysched
  import dcore_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             encrypt,
  input  logic [BLK_W-1:0] key_in,
  input  logic [CNT_W-1:0] cnt,
  output logic [SUB_W-1:0] subkey
);

  logic [CD_W-1:0] cd_q;
  logic [CD_W-1:0] cd_base;
  logic [CD_W-1:0] cd_next;
  logic            fwd_q;
  int              fwd_amt;
  int              rev_amt;

  assign cd_base = key_select(key_in);
  assign fwd_amt = shift_of(int'(cnt) + 2);
  assign rev_amt = shift_of(ROUNDS - int'(cnt));
  assign cd_next = fwd_q ? rot_cd(cd_q, fwd_amt, 1'b1) : rot_cd(cd_q, rev_amt, 1'b0);
  assign subkey  = key_compress(cd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q  <= '0;
      fwd_q <= 1'b1;
    end else if (load) begin
      cd_q  <= encrypt ? rot_cd(cd_base, 1, 1'b1) : cd_base;
      fwd_q <= encrypt;
    end else if (step) begin
      cd_q <= cd_next;
    end
  end

  a_r3_direction_held: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(fwd_q));

endmodule

// File: rtl/dcore_round.sv
module dcore_round
  import dcore_pkg::*;
(
  input  logic [HALF_W-1:0] left_in,
  input  logic [HALF_W-1:0] right_in,
  input  logic [SUB_W-1:0]  subkey,
  output logic [HALF_W-1:0] left_out,
  output logic [HALF_W-1:0] right_out
);

  logic [SUB_W-1:0]  mixed;
  logic [HALF_W-1:0] sub_out;
  logic [HALF_W-1:0] feistel_f;

  assign mixed = expand(right_in) ^ subkey;

  for (genvar g = 0; g < NSBOX; g++) begin : g_sbox
    assign sub_out[HALF_W-1-4*g -: 4] = sbox_lookup(g, mixed[SUB_W-1-6*g -: 6]);
  end

  assign feistel_f = pbox(sub_out);
  assign left_out  = right_in;
  assign right_out = left_in ^ feistel_f;

endmodule

// File: rtl/des_iter_core.sv
module des_iter_core
  import dcore_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        encrypt,
  input  logic [63:0] key_in,
  input  logic [63:0] block_in,
  output logic [63:0] block_out,
  output logic        done
);

  logic             accept;
  logic             busy;
  logic             last;
  logic [CNT_W-1:0] cnt;
  logic [SUB_W-1:0] subkey;
  logic [HALF_W-1:0] l_q, r_q, l_nx, r_nx;
  logic [BLK_W-1:0] permuted;
  logic [BLK_W-1:0] res_q;

  dcore_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .last   (last),
    .done   (done),
    .cnt    (cnt)
  );

  dcore_keysched u_ks (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step    (busy),
    .encrypt (encrypt),
    .key_in  (key_in),
    .cnt     (cnt),
    .subkey  (subkey)
  );

  dcore_round u_round (
    .left_in   (l_q),
    .right_in  (r_q),
    .subkey    (subkey),
    .left_out  (l_nx),
    .right_out (r_nx)
  );

  assign permuted = perm_in(block_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q   <= '0;
      r_q   <= '0;
      res_q <= '0;
    end else if (accept) begin
      l_q <= permuted[BLK_W-1:HALF_W];
      r_q <= permuted[HALF_W-1:0];
    end else if (busy) begin
      l_q <= l_nx;
      r_q <= r_nx;
      if (last) res_q <= perm_out({r_nx, l_nx});
    end
  end

  assign block_out = res_q;

  a_r5_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(block_out));

  a_r1_output_only_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(last) |-> $stable(block_out));

endmodule

// File: tb/sim_des_iter_core.sv
module sim_des_iter_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        encrypt = 1'b1;
  logic [63:0] key_in = '0;
  logic [63:0] block_in = '0;
  logic [63:0] block_out;
  logic        done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  localparam logic [63:0] K1 = 64'h133457799BBCDFF1;
  localparam logic [63:0] P1 = 64'h0123456789ABCDEF;
  localparam logic [63:0] C1 = 64'h85E813540F0AB405;
  localparam logic [63:0] K2 = 64'h0E329232EA6D0D73;
  localparam logic [63:0] P2 = 64'h8787878787878787;
  localparam logic [63:0] PAR = 64'h0101010101010101;

  always #10 clk = ~clk;

  des_iter_core u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .encrypt(encrypt),
    .key_in(key_in), .block_in(block_in), .block_out(block_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R4 watchdog actual=%0d expected=below 20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Model: done stays low for 15 cycles after acceptance, high after the 16th edge.
  task automatic run(input bit enc, input logic [63:0] k, input logic [63:0] d,
                     input bit poke, output logic [63:0] res);
    @(negedge clk);
    start = 1'b1; encrypt = enc; key_in = k; block_in = d;
    @(negedge clk);
    start = 1'b0; encrypt = ~enc; key_in = ~k; block_in = d ^ 64'hA5A5_5A5A_F00F_0FF0;
    chk(done == 1'b0, "R5 done drops on accepted start", 64'(done), 64'd0);
    for (int c = 1; c <= 16; c++) begin
      if (poke && c == 5) begin
        start = 1'b1; block_in = 64'hDEAD_BEEF_0000_FFFF; key_in = 64'h0;
      end
      @(negedge clk);
      start = 1'b0;
      chk(done == (c == 16), "R4 done timing", 64'(done), 64'(c == 16));
    end
    res = block_out;
  endtask

  task automatic hold(input int n, input logic [63:0] exp);
    for (int i = 0; i < n; i++) begin
      key_in = key_in + 64'h1111; block_in = ~block_in; encrypt = ~encrypt;
      @(negedge clk);
      chk(done == 1'b1 && block_out == exp, "R5 result held", block_out, exp);
    end
  endtask

  initial begin
    logic [63:0] r;
    logic [63:0] t;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && block_out == 64'd0, "R1 reset state", block_out, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && block_out == 64'd0, "R1 idle after reset", block_out, 64'd0);

    run(1'b1, K1, P1, 1'b0, r);
    chk(r == C1, "R2 known answer encrypt", r, C1);
    hold(4, C1);

    run(1'b0, K1, C1, 1'b0, r);
    chk(r == P1, "R3 known answer decrypt", r, P1);

    run(1'b1, K2, P2, 1'b0, r);
    chk(r == 64'd0, "R2 second vector encrypt", r, 64'd0);
    run(1'b0, K2, 64'd0, 1'b0, r);
    chk(r == P2, "R3 second vector decrypt", r, P2);

    run(1'b1, K1 ^ PAR, P1, 1'b0, r);
    chk(r == C1, "R7 parity bits ignored", r, C1);
    run(1'b0, K1 ^ PAR, C1, 1'b0, r);
    chk(r == P1, "R7 parity bits ignored decrypt", r, P1);

    run(1'b1, ~K1, ~P1, 1'b0, r);
    chk(r == ~C1, "R8 complementation", r, ~C1);

    run(1'b1, K1, P1, 1'b1, r);
    chk(r == C1, "R6 start ignored while busy", r, C1);
    hold(2, C1);

    run(1'b1, PAR, P2, 1'b0, t);
    run(1'b1, PAR, t, 1'b0, r);
    chk(r == P2, "R9 weak key involution", r, P2);
    run(1'b1, PAR, P1, 1'b0, t);
    run(1'b1, PAR, t, 1'b0, r);
    chk(r == P1, "R9 weak key involution second block", r, P1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule